// File: doc/BRIEF.md
# Frame Identifier Acceptance Filter

This block decides, for a slave on a broadcast serial bus, whether a frame whose header has just been received concerns this node. On the bus an identifier names the content of a frame, not a destination, so every slave sees every header. The block compares the 6-bit identifier of each header against a bank of eight programmable filter registers. When a filter matches, the block raises a hit and reports which filter matched, so that software is called only for frames it must handle. When no filter matches, nothing is raised and the frame passes unnoticed.

The filters form four pairs: filters 0/1, 2/3, 4/5 and 6/7. Each pair has its own mode bit. In exact mode, which is the reset default, each filter of the pair holds one identifier that must match on every bit. In masked mode, the even filter of the pair holds an identifier and the odd filter holds a bit mask. The masked filter then accepts a whole group of identifiers, so a slave can take more identifiers than it has filter registers. The filter contents, the enable bits and the mode bits come in as plain inputs from a register block outside this one. The hit flag and the index are registered and appear one clock after the identifier strobe.

Top module: `idfilt_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `match_hit` is 0 and `match_idx` is 0.
- R2: With a pair in exact mode (`pair_mask_mode` bit = 0), filter i hits when it is enabled and the received identifier equals the 6 bits in `filt_val[6*i +: 6]` exactly.
- R3: With a pair in masked mode (`pair_mask_mode` bit = 1), the even filter 2p holds the identifier and the odd filter 2p+1 holds the mask. A mask bit of 1 means the identifier bit must match and a mask bit of 0 means don't-care. A hit is reported with the even index 2p.
- R4: In a masked pair the odd filter never reports a hit of its own, even when the received identifier equals the value in the odd register.
- R5: A filter whose `filt_en` bit is 0 never hits. In a masked pair only the enable bit of the even filter counts, and the enable bit of the odd filter has no effect.
- R6: When several filters hit on the same identifier, `match_idx` reports the lowest-numbered one.
- R7: When no enabled filter matches, `match_hit` is 0 and `match_idx` is 0, so no request is raised.
- R8: `match_hit` and `match_idx` show the result for the identifier that was present with `hdr_valid` exactly one clock earlier. In any cycle that follows a clock without `hdr_valid`, `match_hit` is 0.
- R9: Each pair follows its own mode bit, so exact and masked pairs can be mixed within one bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | One-cycle strobe: a header identifier is present |
| hdr_id | input | 6 | Received frame identifier |
| filt_val | input | 48 | Filter register contents, filter i in bits [6*i+5:6*i] |
| filt_en | input | 8 | Per-filter enable, bit i for filter i |
| pair_mask_mode | input | 4 | Per-pair mode, bit p for filters 2p/2p+1: 0 exact, 1 masked |
| match_hit | output | 1 | Registered: a filter accepted the last strobed identifier |
| match_idx | output | 3 | Registered: lowest matching filter index, 0 when there is no hit |

## Verification
The bench drives all 64 identifiers through an exact-mode bank with distinct values, then through a bank with one masked pair. These two sweeps separate exact equality from masked comparison and show which identifier groups a given mask opens. Duplicated values and partly disabled banks expose the priority order and the enable rules, including the unused enable bit of an odd mask register. Strobe gaps in which the identifier lines still carry a matching value show that the hit comes only from the strobe. A run of randomized mixed-mode configurations then checks every pair mode against the others.

// File: rtl/idf_pkg.sv
package idf_pkg;

  typedef enum logic {
    PAIR_EXACT  = 1'b0,
    PAIR_MASKED = 1'b1
  } pair_mode_e;

endpackage

// File: rtl/idf_pair.sv
module idf_pair #(
  parameter int ID_W = 6
) (
  input  logic [ID_W-1:0] hdr_id,
  input  logic [ID_W-1:0] val_even,
  input  logic [ID_W-1:0] val_odd,
  input  logic            en_even,
  input  logic            en_odd,
  input  logic            mode_bit,
  output logic            hit_even,
  output logic            hit_odd
);
  import idf_pkg::*;

  function automatic logic exact_eq(input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    return (a == b);
  endfunction

  function automatic logic masked_eq(input logic [ID_W-1:0] a,
                                     input logic [ID_W-1:0] ref_id,
                                     input logic [ID_W-1:0] care);
    return (((a ^ ref_id) & care) == '0);
  endfunction

  pair_mode_e mode;
  logic       even_exact_ok;
  logic       odd_exact_ok;
  logic       even_masked_ok;

  assign mode           = pair_mode_e'(mode_bit);
  assign even_exact_ok  = exact_eq(hdr_id, val_even);
  assign odd_exact_ok   = exact_eq(hdr_id, val_odd);
  assign even_masked_ok = masked_eq(hdr_id, val_even, val_odd);

  always_comb begin
    hit_even = 1'b0;
    hit_odd  = 1'b0;
    unique case (mode)
      PAIR_EXACT: begin
        hit_even = en_even & even_exact_ok;
        hit_odd  = en_odd  & odd_exact_ok;
      end
      PAIR_MASKED: begin
        hit_even = en_even & even_masked_ok;
        hit_odd  = 1'b0;
      end
      default: begin
        hit_even = 1'b0;
        hit_odd  = 1'b0;
      end
    endcase
  end

  // The odd filter of a masked pair is a mask and has no hit of its own (R4)
  always_comb begin
    if (mode == PAIR_MASKED)
      assert_odd_silent_masked_R4: assert (!hit_odd);
  end

  // A disabled identifier register never produces a hit (R5)
  always_comb begin
    if (!en_even)
      assert_disabled_even_quiet_R5: assert (!hit_even);
    if (!en_odd)
      assert_disabled_odd_quiet_R5: assert (!hit_odd);
  end

endmodule

// File: rtl/idf_prio.sv
module idf_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
  end

  assign any = |req;

  // At most one filter is granted, and it is one that requested (R6)
  always_comb begin
    assert_single_grant_R6: assert ($onehot0(grant));
    assert_grant_is_request_R6: assert ((grant & ~req) == '0);
    assert_grant_when_any_R6: assert (any == (grant != '0));
  end

endmodule

// File: rtl/idfilt_bank.sv
module idfilt_bank #(
  parameter int ID_W   = 6,
  parameter int N_FILT = 8,
  localparam int N_PAIR = N_FILT / 2,
  localparam int IDX_W  = $clog2(N_FILT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  input  logic [ID_W-1:0]        hdr_id,
  input  logic [N_FILT*ID_W-1:0] filt_val,
  input  logic [N_FILT-1:0]      filt_en,
  input  logic [N_PAIR-1:0]      pair_mask_mode,
  output logic                   match_hit,
  output logic [IDX_W-1:0]       match_idx
);

  logic [N_FILT-1:0] raw_hit;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic [N_FILT-1:0] win_grant;

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    idf_pair #(.ID_W(ID_W)) u_pair (
      .hdr_id   (hdr_id),
      .val_even (filt_val[(2*p)*ID_W +: ID_W]),
      .val_odd  (filt_val[(2*p+1)*ID_W +: ID_W]),
      .en_even  (filt_en[2*p]),
      .en_odd   (filt_en[2*p+1]),
      .mode_bit (pair_mask_mode[p]),
      .hit_even (raw_hit[2*p]),
      .hit_odd  (raw_hit[2*p+1])
    );
  end

  idf_prio #(.N(N_FILT), .IDX_W(IDX_W)) u_prio (
    .req   (raw_hit),
    .any   (any_hit),
    .idx   (win_idx),
    .grant (win_grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_hit <= 1'b0;
      match_idx <= '0;
    end else if (hdr_valid && any_hit) begin
      match_hit <= 1'b1;
      match_idx <= win_idx;
    end else begin
      match_hit <= 1'b0;
      match_idx <= '0;
    end
  end

  // A hit only follows a strobe in the previous clock (R8)
  assert_quiet_without_strobe_R8: assert property (
    @(posedge clk) disable iff (!rst_n) !hdr_valid |=> !match_hit);

  // A miss reports index zero (R7)
  assert_idx_zero_on_miss_R7: assert property (
    @(posedge clk) disable iff (!rst_n) !match_hit |-> (match_idx == '0));

  // A strobe that some filter accepts shows up as a hit one clock later (R8)
  assert_hit_follows_accept_R8: assert property (
    @(posedge clk) disable iff (!rst_n) (hdr_valid && (win_grant != '0)) |=> match_hit);

endmodule

// File: tb/idfilt_bank_tb_top.sv
module idfilt_bank_tb_top;
  localparam int ID_W = 6;
  localparam int NF   = 8;
  localparam int NP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [ID_W-1:0] hdr_id = '0;
  logic [ID_W-1:0] fv [NF];
  logic [NF-1:0] en = '0;
  logic [NP-1:0] mm = '0;
  logic [NF*ID_W-1:0] filt_val;
  logic match_hit;
  logic [2:0] match_idx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  string cur_tag = "R1";
  string exp_tag = "R1";
  logic exp_hit = 1'b0;
  int exp_idx = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NF; i++) filt_val[i*ID_W +: ID_W] = fv[i];
  end

  idfilt_bank dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .filt_val(filt_val), .filt_en(en), .pair_mask_mode(mm),
    .match_hit(match_hit), .match_idx(match_idx)
  );

  // Behavioural model: first acceptable filter scanning upward, -1 for none
  function automatic int model(input logic [ID_W-1:0] id);
    for (int i = 0; i < NF; i++) begin
      if (mm[i/2]) begin
        if ((i % 2) == 0 && en[i]) begin
          logic ok = 1'b1;
          for (int b = 0; b < ID_W; b++)
            if (fv[i+1][b] && (id[b] != fv[i][b])) ok = 1'b0;
          if (ok) return i;
        end
      end else if (en[i] && id == fv[i]) begin
        return i;
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    int r;
    r = model(hdr_id);
    if (!rst_n) begin
      exp_hit <= 1'b0; exp_idx <= 0; exp_tag <= "R1";
    end else if (hdr_valid && r >= 0) begin
      exp_hit <= 1'b1; exp_idx <= r; exp_tag <= cur_tag;
    end else begin
      exp_hit <= 1'b0; exp_idx <= 0; exp_tag <= cur_tag;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 1 && !done) begin
      total++;
      if (match_hit !== exp_hit || int'(match_idx) != exp_idx) begin
        bad++;
        $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                 exp_tag, match_hit, match_idx, exp_hit, exp_idx);
      end
    end
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic strobe(input logic [ID_W-1:0] id, input string tag);
    @(negedge clk);
    cur_tag = tag; hdr_valid = 1'b1; hdr_id = id;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic idle(input logic [ID_W-1:0] id, input int n, input string tag);
    @(negedge clk);
    cur_tag = tag; hdr_valid = 1'b0; hdr_id = id;
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_exact();
    @(negedge clk);
    for (int i = 0; i < NF; i++) fv[i] = ID_W'(i * 7 + 3);
    en = '1; mm = '0;
  endtask

  initial begin
    for (int i = 0; i < NF; i++) fv[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    @(negedge clk);

    // R2: exact mode, each filter value
    cfg_exact();
    for (int i = 0; i < NF; i++) strobe(fv[i], "R2");
    for (int k = 0; k < 64; k++) strobe(ID_W'(k), "R2");
    // R7: identifiers in no filter
    strobe(6'd0, "R7"); strobe(6'd1, "R7"); strobe(6'd63, "R7");
    // R8: matching identifier without strobe, then back-to-back strobes
    idle(fv[4], 5, "R8");
    @(negedge clk); cur_tag = "R8"; hdr_valid = 1'b1; hdr_id = fv[2];
    @(negedge clk); hdr_id = fv[6];
    @(negedge clk); hdr_id = 6'd0;
    @(negedge clk); hdr_valid = 1'b0;
    idle(fv[6], 3, "R8");

    // R6: duplicated values, lowest index wins
    @(negedge clk); fv[6] = fv[1]; fv[3] = fv[1];
    strobe(fv[1], "R6");
    @(negedge clk); en[1] = 1'b0;
    strobe(fv[3], "R6");
    // R5: disabled filters never hit
    @(negedge clk); en[3] = 1'b0;
    strobe(fv[6], "R5");
    @(negedge clk); en = '0;
    for (int k = 0; k < 64; k++) strobe(ID_W'(k), "R5");

    // R3: pair 1 masked, identifier 101010, mask 110000
    cfg_exact();
    @(negedge clk); mm[1] = 1'b1; fv[2] = 6'b101010; fv[3] = 6'b110000;
    for (int k = 0; k < 64; k++) strobe(ID_W'(k), "R3");
    strobe(6'd40, "R3");
    // R4: value of the odd register alone gives no hit
    strobe(6'd48, "R4");
    // R5: odd enable irrelevant in masked pair, even enable governs
    @(negedge clk); en[3] = 1'b0;
    strobe(6'd40, "R5");
    @(negedge clk); en[3] = 1'b1; en[2] = 1'b0;
    strobe(6'd40, "R5");
    // R9: all pairs masked with empty masks accept anything at index 0
    @(negedge clk); en = '1; mm = '1;
    for (int p = 0; p < NP; p++) fv[2*p+1] = '0;
    strobe(6'd17, "R9");
    @(negedge clk); en[0] = 1'b0;
    strobe(6'd17, "R9");
    // R9: randomized mixed configurations
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      for (int i = 0; i < NF; i++) fv[i] = ID_W'($urandom);
      en = NF'($urandom); mm = NP'($urandom);
      for (int k = 0; k < 4; k++) strobe(fv[$urandom % NF] ^ ID_W'($urandom % 4), "R9");
    end

    idle(6'd0, 3, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule